// File: doc/BRIEF.md
# Page Protection Uniformity Classifier

This combinational block decides whether an address translation cache may hold an entry for a whole page, or whether it must fall back to caching a single byte. It takes a physical address and the already decoded inclusive start and end bounds of every protection entry, with a flag per entry that says whether the entry is enabled. From the address it forms the surrounding page. It then reports whether protection is uniform across that page.

The entries are ranked by index, and index 0 has the highest priority. Only the highest priority enabled entry that touches the page matters. If that entry spans the whole page, the page is uniform. If one of its bounds lands inside the page, protection changes within the page, so caching must be restricted to one byte. If no enabled entry touches the page, or protection is built out by parameter, the page is uniform. The block does not compute permissions and does not decode entries.

Top module: `pg_uniform_classifier`

## Requirements
- R1: The page is the span from the address with its low `PAGE_BITS` bits cleared up to that value plus 2^`PAGE_BITS` - 1, both ends inclusive. Entry bounds are inclusive and are compared against this span.
- R2: An entry whose enable bit is 0 has no effect on the result, whatever its bounds are.
- R3: Among the enabled entries that touch the page, only the one with the lowest index decides the result. Every entry with a higher index is ignored.
- R4: If the deciding entry has start <= page start and end >= page end, `full_page_o` is 1.
- R5: If the deciding entry does not span the page and its start lies within the page, `full_page_o` is 0.
- R6: If the deciding entry does not span the page and its end lies within the page, `full_page_o` is 0.
- R7: If no enabled entry spans the page or has a bound inside it, `full_page_o` is 1.
- R8: With every enable bit at 0, `full_page_o` is 1 for any address.
- R9: An entry that spans the page gives 1 even when one of its bounds sits exactly on a page edge.
- R10: When the parameter `PROT_IMPL` is 0, `full_page_o` is 1 for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | ADDR_W | Physical address being looked up |
| ent_lo_i | input | N_ENT x ADDR_W | Inclusive start bound of each entry |
| ent_hi_i | input | N_ENT x ADDR_W | Inclusive end bound of each entry |
| ent_on_i | input | N_ENT | Enable per entry; 0 means the match mode is off |
| full_page_o | output | 1 | 1 means the whole page may be cached; 0 means cache a single byte only |

## Verification
Immediate assertions check the following on every evaluation:
- The page span has the right size and contains the address.
- The priority grant is one-hot or empty.
- The grant goes only to an enabled candidate that has no candidate below it.
- The output matches the kind of the granted entry, or is 1 when nothing is granted.

Some properties only the bench scenarios can show:
- The result comes from the lowest index when two entries disagree.
- A disabled entry that overlaps the page is really ignored.
- The edges of the page are placed exactly at the first and last byte.
- The variant with protection built out reports a full page.

// File: rtl/pg_uniform_pkg.sv
package pg_uniform_pkg;

   // Relation of one entry to the current page
   typedef struct packed {
      logic spans;   // entry bounds enclose the whole page
      logic edge_in; // at least one entry bound lies inside the page
      logic cand;    // enabled and touching the page
   } ent_rel_t;

   function automatic logic in_span(input logic [63:0] v,
                                    input logic [63:0] lo,
                                    input logic [63:0] hi);
      return (v >= lo) && (v <= hi);
   endfunction

endpackage

// File: rtl/pg_page_span.sv
module pg_page_span #(
   parameter int ADDR_W    = 34,
   parameter int PAGE_BITS = 12
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] page_lo_o,
   output logic [ADDR_W-1:0] page_hi_o
);
   localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((64'd1 << PAGE_BITS) - 64'd1);

   assign page_lo_o = addr_i & ~OFF_MASK;
   assign page_hi_o = addr_i | OFF_MASK;

   always_comb begin
      // R1: span size and containment
      a_r1_page_span : assert ((page_hi_o - page_lo_o) == OFF_MASK
                               && addr_i >= page_lo_o && addr_i <= page_hi_o)
         else $error("page span malformed");
   end
endmodule

// File: rtl/pg_entry_rel.sv
module pg_entry_rel
   import pg_uniform_pkg::*;
#(
   parameter int ADDR_W = 34
) (
   input  logic [ADDR_W-1:0] page_lo_i,
   input  logic [ADDR_W-1:0] page_hi_i,
   input  logic [ADDR_W-1:0] lo_i,
   input  logic [ADDR_W-1:0] hi_i,
   input  logic              on_i,
   output ent_rel_t          rel_o
);
   logic lo_inside, hi_inside;

   assign lo_inside = in_span(64'(lo_i), 64'(page_lo_i), 64'(page_hi_i));
   assign hi_inside = in_span(64'(hi_i), 64'(page_lo_i), 64'(page_hi_i));

   always_comb begin
      rel_o.spans   = (lo_i <= page_lo_i) && (hi_i >= page_hi_i);
      rel_o.edge_in = lo_inside || hi_inside;
      rel_o.cand    = on_i && (rel_o.spans || rel_o.edge_in);
   end
endmodule

// File: rtl/pg_prio_pick.sv
module pg_prio_pick
   import pg_uniform_pkg::*;
#(
   parameter int N_ENT = 16
) (
   input  ent_rel_t [N_ENT-1:0] rel_i,
   input  logic     [N_ENT-1:0] on_i,
   output logic     [N_ENT-1:0] grant_o,
   output logic                 hit_o,
   output logic                 hit_spans_o
);
   logic [N_ENT-1:0] cand;
   logic [N_ENT-1:0] spans;

   for (genvar g = 0; g < N_ENT; g++) begin : g_unpack
      assign cand[g]  = rel_i[g].cand;
      assign spans[g] = rel_i[g].spans;
   end

   always_comb begin
      logic taken;
      taken   = 1'b0;
      grant_o = '0;
      for (int i = 0; i < N_ENT; i++) begin
         grant_o[i] = cand[i] && !taken;
         taken      = taken || cand[i];
      end
   end

   assign hit_o       = |grant_o;
   assign hit_spans_o = |(grant_o & spans);

   always_comb begin
      // R3: at most one winner
      a_r3_single_grant : assert ($onehot0(grant_o))
         else $error("multiple grants");
      for (int i = 0; i < N_ENT; i++) begin
         // R2: a winner is always enabled
         a_r2_grant_enabled : assert (!grant_o[i] || on_i[i])
            else $error("grant to disabled entry");
         // R3: nothing lower in index may also be a candidate
         a_r3_lowest_wins : assert (!grant_o[i] || (cand & ((N_ENT'(1) << i) - N_ENT'(1))) == '0)
            else $error("grant skipped a lower candidate");
      end
   end
endmodule

// File: rtl/pg_uniform_classifier.sv
module pg_uniform_classifier
   import pg_uniform_pkg::*;
#(
   parameter int ADDR_W    = 34,
   parameter int N_ENT     = 16,
   parameter int PAGE_BITS = 12,
   parameter bit PROT_IMPL = 1'b1
) (
   input  logic [ADDR_W-1:0]            addr_i,
   input  logic [N_ENT-1:0][ADDR_W-1:0] ent_lo_i,
   input  logic [N_ENT-1:0][ADDR_W-1:0] ent_hi_i,
   input  logic [N_ENT-1:0]             ent_on_i,
   output logic                         full_page_o
);
   if (N_ENT < 1)                        begin : g_bad_n   $error("N_ENT must be >= 1"); end
   if (ADDR_W < 2 || ADDR_W > 64)        begin : g_bad_w   $error("ADDR_W out of range"); end
   if (PAGE_BITS < 1 || PAGE_BITS >= ADDR_W) begin : g_bad_pg $error("PAGE_BITS out of range"); end

   if (PROT_IMPL) begin : g_prot
      logic [ADDR_W-1:0]     page_lo, page_hi;
      ent_rel_t [N_ENT-1:0]  rel;
      logic [N_ENT-1:0]      grant;
      logic                  hit, hit_spans;

      pg_page_span #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_span (
         .addr_i   (addr_i),
         .page_lo_o(page_lo),
         .page_hi_o(page_hi)
      );

      for (genvar e = 0; e < N_ENT; e++) begin : g_ent
         pg_entry_rel #(.ADDR_W(ADDR_W)) u_rel (
            .page_lo_i(page_lo),
            .page_hi_i(page_hi),
            .lo_i     (ent_lo_i[e]),
            .hi_i     (ent_hi_i[e]),
            .on_i     (ent_on_i[e]),
            .rel_o    (rel[e])
         );
      end

      pg_prio_pick #(.N_ENT(N_ENT)) u_pick (
         .rel_i      (rel),
         .on_i       (ent_on_i),
         .grant_o    (grant),
         .hit_o      (hit),
         .hit_spans_o(hit_spans)
      );

      assign full_page_o = !hit || hit_spans;

      always_comb begin
         // R4, R9
         a_r4_span_full : assert (!(hit && hit_spans) || full_page_o)
            else $error("spanning winner not full page");
         // R5, R6
         a_r5_edge_nocache : assert (!(hit && !hit_spans) || !full_page_o)
            else $error("edge winner allowed full page");
         // R7
         a_r7_idle_full : assert (hit || full_page_o)
            else $error("no winner but not full page");
         // R8
         a_r8_all_off : assert (ent_on_i != '0 || full_page_o)
            else $error("all entries off but not full page");
      end
   end else begin : g_noprot
      assign full_page_o = 1'b1;
      always_comb begin
         // R10
         a_r10_absent_full : assert (full_page_o)
            else $error("protection absent but not full page");
      end
   end
endmodule

// File: tb/pg_uniform_classifier_tb.sv
module pg_uniform_classifier_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 34;
   localparam int NE = 16;
   localparam int WATCHDOG = 5000;

   typedef struct packed {
      logic [AW-1:0] addr;
      logic [3:0]    ia;
      logic [AW-1:0] alo;
      logic [AW-1:0] ahi;
      logic          ona;
      logic [3:0]    ib;
      logic [AW-1:0] blo;
      logic [AW-1:0] bhi;
      logic          onb;
      logic          exp;
      logic [7:0]    req;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      // R4: exact page cover
      '{34'h0_8000_0123, 4'd3, 34'h0_8000_0000, 34'h0_8000_0FFF, 1'b1, 4'd0, 34'h0, 34'h0, 1'b0, 1'b1, 8'd4},
      // R4: whole address space
      '{34'h0_8000_0123, 4'd0, 34'h0_0000_0000, 34'h3_FFFF_FFFF, 1'b1, 4'd0, 34'h0, 34'h0, 1'b0, 1'b1, 8'd4},
      // R5: small region inside page
      '{34'h0_8000_0123, 4'd2, 34'h0_8000_0008, 34'h0_8000_000F, 1'b1, 4'd0, 34'h0, 34'h0, 1'b0, 1'b0, 8'd5},
      // R6: end falls inside page
      '{34'h0_8000_0123, 4'd5, 34'h0_7000_0000, 34'h0_8000_0800, 1'b1, 4'd0, 34'h0, 34'h0, 1'b0, 1'b0, 8'd6},
      // R7: entry elsewhere
      '{34'h0_8000_0123, 4'd1, 34'h0_9000_0000, 34'h0_9000_0FFF, 1'b1, 4'd0, 34'h0, 34'h0, 1'b0, 1'b1, 8'd7},
      // R2: disabled edge entry ignored, later cover decides
      '{34'h0_8000_0123, 4'd0, 34'h0_8000_0008, 34'h0_8000_000F, 1'b0, 4'd7, 34'h0_8000_0000, 34'h0_8000_0FFF, 1'b1, 1'b1, 8'd2},
      // R3: lower edge entry beats later cover
      '{34'h0_8000_0123, 4'd1, 34'h0_8000_0008, 34'h0_8000_000F, 1'b1, 4'd4, 34'h0_0000_0000, 34'h3_FFFF_FFFF, 1'b1, 1'b0, 8'd3},
      // R3: lower cover beats later edge entry
      '{34'h0_8000_0123, 4'd1, 34'h0_8000_0000, 34'h0_8000_0FFF, 1'b1, 4'd4, 34'h0_8000_0008, 34'h0_8000_000F, 1'b1, 1'b1, 8'd3},
      // R9: start on page start, end beyond
      '{34'h0_8000_0123, 4'd6, 34'h0_8000_0000, 34'h0_8000_1FFF, 1'b1, 4'd0, 34'h0, 34'h0, 1'b0, 1'b1, 8'd9},
      // R1: start on last byte of page
      '{34'h0_8000_0123, 4'd0, 34'h0_8000_0FFF, 34'h0_8000_2000, 1'b1, 4'd0, 34'h0, 34'h0, 1'b0, 1'b0, 8'd1},
      // R1: start one past page end, not touching
      '{34'h0_8000_0123, 4'd0, 34'h0_8000_1000, 34'h0_8000_1FFF, 1'b1, 4'd0, 34'h0, 34'h0, 1'b0, 1'b1, 8'd1},
      // R1: end one below page start, not touching
      '{34'h0_8000_0123, 4'd0, 34'h0_7000_0000, 34'h0_7FFF_FFFF, 1'b1, 4'd0, 34'h0, 34'h0, 1'b0, 1'b1, 8'd1},
      // R5: highest index entry still decides when alone
      '{34'h0_8000_0123, 4'd15, 34'h0_8000_0100, 34'h0_8000_5000, 1'b1, 4'd0, 34'h0, 34'h0, 1'b0, 1'b0, 8'd5},
      // R1: address on last byte of page, single-byte entry there
      '{34'h0_8000_0FFF, 4'd8, 34'h0_8000_0FFF, 34'h0_8000_0FFF, 1'b1, 4'd0, 34'h0, 34'h0, 1'b0, 1'b0, 8'd1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [AW-1:0]         addr;
   logic [NE-1:0][AW-1:0] lo, hi;
   logic [NE-1:0]         on;
   logic                  full, full_off;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   pg_uniform_classifier #(.ADDR_W(AW), .N_ENT(NE), .PAGE_BITS(12), .PROT_IMPL(1'b1)) u_dut (
      .addr_i(addr), .ent_lo_i(lo), .ent_hi_i(hi), .ent_on_i(on), .full_page_o(full));

   pg_uniform_classifier #(.ADDR_W(AW), .N_ENT(NE), .PAGE_BITS(12), .PROT_IMPL(1'b0)) u_dut_off (
      .addr_i(addr), .ent_lo_i(lo), .ent_hi_i(hi), .ent_on_i(on), .full_page_o(full_off));

   task automatic check(input logic act, input logic exp, input string req);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic clear_all();
      lo = '0; hi = '0; on = '0;
   endtask

   initial begin
      addr = 34'h0_8000_0123;
      clear_all();
      // R8: reset state, everything disabled
      @(negedge clk);
      check(full, 1'b1, "R8 reset all-off");
      repeat (2) @(posedge clk);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         @(posedge clk);
         clear_all();
         addr = VECS[v].addr;
         lo[VECS[v].ia] = VECS[v].alo; hi[VECS[v].ia] = VECS[v].ahi; on[VECS[v].ia] = VECS[v].ona;
         if (VECS[v].onb || VECS[v].ib != VECS[v].ia) begin
            if (VECS[v].ib != VECS[v].ia) begin
               lo[VECS[v].ib] = VECS[v].blo; hi[VECS[v].ib] = VECS[v].bhi; on[VECS[v].ib] = VECS[v].onb;
            end
         end
         @(negedge clk);
         check(full, VECS[v].exp, $sformatf("R%0d vector %0d", VECS[v].req, v));
      end

      // R8: all disabled but every bound inside page
      @(posedge clk);
      addr = 34'h1_2345_6789;
      for (int i = 0; i < NE; i++) begin
         lo[i] = 34'h1_2345_6010; hi[i] = 34'h1_2345_6020; on[i] = 1'b0;
      end
      @(negedge clk);
      check(full, 1'b1, "R8 disabled edges");

      // R7: all enabled, none touching
      @(posedge clk);
      for (int i = 0; i < NE; i++) begin
         lo[i] = 34'h2_0000_0000 + AW'(i) * 34'h1_0000;
         hi[i] = lo[i] + 34'hFFF; on[i] = 1'b1;
      end
      @(negedge clk);
      check(full, 1'b1, "R7 all enabled far away");

      // R3: entry 0 edge inside, rest cover
      @(posedge clk);
      addr = 34'h0_4000_0abc;
      for (int i = 0; i < NE; i++) begin
         lo[i] = 34'h0; hi[i] = 34'h3_FFFF_FFFF; on[i] = 1'b1;
      end
      lo[0] = 34'h0_4000_0800; hi[0] = 34'h0_4000_0900;
      @(negedge clk);
      check(full, 1'b0, "R3 index0 edge beats covers");

      // R10: protection absent, same stimulus
      check(full_off, 1'b1, "R10 absent variant");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule